// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is an eight-pin general-purpose I/O port on a simple memory-mapped bus with byte-wide data. Each pin is either driven by the port or left as an input, as set by a direction register. Driven pins take their value from an output latch. The pad side has an input vector, an output vector and an output-enable vector.

Pin data is reached through a window of addresses below the control registers. The address of each data access carries a per-pin selection mask in address bits [9:2]. A write changes only the selected pins that are outputs, so software can set or clear a single pin in one bus write, with no read-modify-write sequence. A read returns the synchronised pad levels of the selected pins and zero in all other bit positions.

The bus is a one-cycle strobe interface. Read data is registered and appears in the cycle after the read strobe. The asynchronous active-low reset is released through a two-flop stage, so the port leaves reset two clock edges after `rst_n` rises.

Top module: `gpio_maskport`

## Requirements
- R1: While reset is active, and after reset until the first access, `pad_oe`, `pad_out` and `bus_rdata` are all zero (every pin is an input and the output latch is cleared).
- R2: A write to byte offset 0x400 loads the direction register from `bus_wdata` (bit n = 1 makes pin n an output). `pad_oe` equals the direction register from the next cycle onward, and a read of 0x400 returns it.
- R3: A write with `bus_addr[11:10] == 0` is a data write. For every pin n with `bus_addr[n+2] == 1` that is an output, the output latch bit n takes `bus_wdata[n]`, visible on `pad_out` in the next cycle. All other latch bits keep their value.
- R4: A data write leaves the latch bit of any pin that is an input at that moment unchanged, and it has no deferred effect when the pin is later made an output.
- R5: The output latch keeps its value when pins are switched to input and back to output.
- R6: A read with `bus_addr[11:10] == 0` returns, in bit n, the synchronised `pad_in[n]` if `bus_addr[n+2] == 1`, and 0 otherwise. This holds for output pins too: the value comes from the pad, not from the latch.
- R7: `pad_in` passes through a two-flop synchroniser. A pad change made together with a continuous read strobe shows in `bus_rdata` only after the third rising edge.
- R8: Writes to offsets other than the data window and 0x400 (for example 0x404 or 0x800) change neither `pad_oe` nor `pad_out`. Reads of such offsets return 0.
- R9: `bus_rdata` is updated only in the cycle after a read strobe. It holds its value through writes and idle cycles.
- R10: A data write whose mask bits [9:2] are all zero changes no pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_en | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output levels (output latch) |
| pad_oe | output | 8 | Pad output enables (direction register) |

## Verification
The hardest case to reach from the ports is the input-pin rule. A rejected data write leaves no trace while the pin stays an input, so the stimulus writes all-ones masks to a half-output port and then turns every pin into an output. Only then does `pad_out` show whether a discarded value was held back and applied late. The synchroniser latency is shown by changing `pad_in` in the same cycle as a held read strobe and sampling `bus_rdata` after each of the next three edges.

// File: rtl/gpio_mp_pkg.sv
package gpio_mp_pkg;
  localparam int unsigned GPIO_PINS   = 8;
  localparam int unsigned GPIO_ADDR_W = 12;
  localparam logic [GPIO_ADDR_W-1:0] GPIO_DIR_OFS = 12'h400;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_DATA = 2'd1,
    ACC_DIR  = 2'd2
  } gpio_acc_e;
endpackage

// File: rtl/gpio_mp_rstsync.sv
module gpio_mp_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic stage_q;
  logic done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      done_q  <= stage_q;
    end
  end

  assign rst_q = done_q;
endmodule

// File: rtl/gpio_mp_insync.sv
module gpio_mp_insync #(
  parameter int unsigned PINS = 8
) (
  input  logic            clk,
  input  logic            rst_q,
  input  logic [PINS-1:0] pad_in,
  output logic [PINS-1:0] pin_sync
);
  for (genvar g = 0; g < PINS; g++) begin : g_pin
    logic meta_q;
    logic hold_q;

    always_ff @(posedge clk or negedge rst_q) begin
      if (!rst_q) begin
        meta_q <= 1'b0;
        hold_q <= 1'b0;
      end else begin
        meta_q <= pad_in[g];
        hold_q <= meta_q;
      end
    end

    assign pin_sync[g] = hold_q;
  end
endmodule

// File: rtl/gpio_mp_regs.sv
module gpio_mp_regs #(
  parameter int unsigned PINS = 8
) (
  input  logic            clk,
  input  logic            rst_q,
  input  logic            dir_we,
  input  logic            data_we,
  input  logic [PINS-1:0] pin_mask,
  input  logic [PINS-1:0] wdata,
  output logic [PINS-1:0] dir_q,
  output logic [PINS-1:0] out_q
);
  logic [PINS-1:0] dir_d;
  logic            dir_en;

  always_comb begin
    dir_en = dir_we;
    dir_d  = wdata;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      dir_q <= '0;
    end else if (dir_en) begin
      dir_q <= dir_d;
    end
  end

  for (genvar g = 0; g < PINS; g++) begin : g_latch
    logic bit_en;
    logic bit_d;

    always_comb begin
      bit_en = data_we & pin_mask[g] & dir_q[g];
      bit_d  = wdata[g];
    end

    always_ff @(posedge clk or negedge rst_q) begin
      if (!rst_q) begin
        out_q[g] <= 1'b0;
      end else if (bit_en) begin
        out_q[g] <= bit_d;
      end
    end
  end
endmodule

// File: rtl/gpio_mp_rdpath.sv
module gpio_mp_rdpath #(
  parameter int unsigned PINS = 8
) (
  input  logic                   clk,
  input  logic                   rst_q,
  input  logic                   rd_en,
  input  gpio_mp_pkg::gpio_acc_e rd_kind,
  input  logic [PINS-1:0]        pin_mask,
  input  logic [PINS-1:0]        pin_sync,
  input  logic [PINS-1:0]        dir_q,
  output logic [PINS-1:0]        rdata_q
);
  import gpio_mp_pkg::*;

  logic [PINS-1:0] rdata_d;

  always_comb begin
    unique case (rd_kind)
      ACC_DATA: rdata_d = pin_sync & pin_mask;
      ACC_DIR:  rdata_d = dir_q;
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= rdata_d;
    end
  end
endmodule

// File: rtl/gpio_maskport.sv
module gpio_maskport #(
  parameter int unsigned PINS   = gpio_mp_pkg::GPIO_PINS,
  parameter int unsigned ADDR_W = gpio_mp_pkg::GPIO_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PINS-1:0]   bus_wdata,
  output logic [PINS-1:0]   bus_rdata,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe
);
  import gpio_mp_pkg::*;

  localparam int unsigned MASK_LO = 2;
  localparam int unsigned MASK_HI = PINS + MASK_LO - 1;
  localparam int unsigned WIN_LO  = MASK_HI + 1;
  localparam logic [ADDR_W-1:0] DIR_ADDR = ADDR_W'(GPIO_DIR_OFS);

  logic            rst_q;
  logic [PINS-1:0] pin_sync;
  logic [PINS-1:0] pin_mask;
  logic [PINS-1:0] dir_q;
  logic [PINS-1:0] out_q;
  gpio_acc_e       acc_kind;
  logic            dir_we;
  logic            data_we;
  logic            rd_en;

  always_comb begin
    pin_mask = bus_addr[MASK_HI:MASK_LO];
    if (bus_addr[ADDR_W-1:WIN_LO] == '0) begin
      acc_kind = ACC_DATA;
    end else if (bus_addr == DIR_ADDR) begin
      acc_kind = ACC_DIR;
    end else begin
      acc_kind = ACC_NONE;
    end
    dir_we  = bus_en & bus_we & (acc_kind == ACC_DIR);
    data_we = bus_en & bus_we & (acc_kind == ACC_DATA);
    rd_en   = bus_en & ~bus_we;
  end

  gpio_mp_rstsync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  gpio_mp_insync #(.PINS(PINS)) u_sync (
    .clk      (clk),
    .rst_q    (rst_q),
    .pad_in   (pad_in),
    .pin_sync (pin_sync)
  );

  gpio_mp_regs #(.PINS(PINS)) u_regs (
    .clk      (clk),
    .rst_q    (rst_q),
    .dir_we   (dir_we),
    .data_we  (data_we),
    .pin_mask (pin_mask),
    .wdata    (bus_wdata),
    .dir_q    (dir_q),
    .out_q    (out_q)
  );

  gpio_mp_rdpath #(.PINS(PINS)) u_rd (
    .clk      (clk),
    .rst_q    (rst_q),
    .rd_en    (rd_en),
    .rd_kind  (acc_kind),
    .pin_mask (pin_mask),
    .pin_sync (pin_sync),
    .dir_q    (dir_q),
    .rdata_q  (bus_rdata)
  );

  assign pad_out = out_q;
  assign pad_oe  = dir_q;
endmodule

// File: rtl/gpio_maskport_chk.sv
module gpio_maskport_chk #(
  parameter int unsigned PINS   = 8,
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_q,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [PINS-1:0]   bus_wdata,
  input logic [PINS-1:0]   bus_rdata,
  input logic [PINS-1:0]   pad_out,
  input logic [PINS-1:0]   pad_oe
);
  localparam logic [ADDR_W-1:0] DIR_ADDR = ADDR_W'(gpio_mp_pkg::GPIO_DIR_OFS);

  logic            win_hit;
  logic [PINS-1:0] sel;

  assign win_hit = (bus_addr[ADDR_W-1:PINS+2] == '0);
  assign sel     = bus_addr[PINS+1:2];

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |-> (pad_oe == '0 && pad_out == '0 && bus_rdata == '0));

  p_oe_load_r2: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_en && bus_we && bus_addr == DIR_ADDR) |=> (pad_oe == $past(bus_wdata)));

  p_oe_stable_r8: assert property (@(posedge clk) disable iff (!rst_q)
    !(bus_en && bus_we && bus_addr == DIR_ADDR) |=> $stable(pad_oe));

  p_out_masked_r3: assert property (@(posedge clk) disable iff (!rst_q)
    !(bus_en && bus_we && win_hit) |=> $stable(pad_out));

  p_out_sel_only_r3: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_en && bus_we && win_hit) |=> (((pad_out ^ $past(pad_out)) & ~$past(sel)) == '0));

  p_input_hold_r4: assert property (@(posedge clk) disable iff (!rst_q)
    1'b1 |=> (((pad_out ^ $past(pad_out)) & ~$past(pad_oe)) == '0));

  p_rd_unsel_zero_r6: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_en && !bus_we && win_hit) |=> ((bus_rdata & ~$past(sel)) == '0));

  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_q)
    !(bus_en && !bus_we) |=> $stable(bus_rdata));
endmodule

bind gpio_maskport gpio_maskport_chk #(.PINS(PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rst_q     (rst_q),
  .bus_en    (bus_en),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe)
);

// File: tb/gpio_maskport_tb.sv
module gpio_maskport_tb;
  logic        clk;
  logic        rst_n;
  logic        bus_en;
  logic        bus_we;
  logic [11:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic [7:0]  pad_in;
  logic [7:0]  pad_out;
  logic [7:0]  pad_oe;

  int checks;
  int fails;
  bit done;

  gpio_maskport u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [7:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [7:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  // mask m -> data-window address with bits [9:2] = m
  function automatic logic [11:0] win(input logic [7:0] m);
    return {2'b00, m, 2'b00};
  endfunction

  task automatic t_reset();
    check("R1 pad_oe in reset", pad_oe, 8'h00);
    check("R1 pad_out in reset", pad_out, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 rdata after reset", bus_rdata, 8'h00);
    check("R1 pad_oe after reset", pad_oe, 8'h00);
  endtask

  task automatic t_dir();
    logic [7:0] r;
    bus_write(12'h400, 8'hA5);
    check("R2 pad_oe follows dir", pad_oe, 8'hA5);
    bus_read(12'h400, r);
    check("R2 dir readback", r, 8'hA5);
  endtask

  task automatic t_masked_write();
    bus_write(12'h400, 8'hFF);
    bus_write(win(8'h0F), 8'hFF);
    check("R3 low-nibble mask write", pad_out, 8'h0F);
    bus_write(win(8'h04), 8'h00);
    check("R3 single pin clear", pad_out, 8'h0B);
    bus_write(win(8'h00), 8'hFF);
    check("R10 empty mask no change", pad_out, 8'h0B);
  endtask

  task automatic t_input_ignore();
    bus_write(12'h400, 8'h0F);
    bus_write(win(8'hFF), 8'hF0);
    check("R4 input pins unchanged", pad_out, 8'h00);
    bus_write(12'h400, 8'hFF);
    check("R4 no deferred effect", pad_out, 8'h00);
    bus_write(win(8'hFF), 8'hF0);
    check("R4 rewrite after output", pad_out, 8'hF0);
  endtask

  task automatic t_retain();
    bus_write(12'h400, 8'h00);
    check("R5 oe off", pad_oe, 8'h00);
    check("R5 latch kept as input", pad_out, 8'hF0);
    bus_write(12'h400, 8'hFF);
    check("R5 latch kept back to output", pad_out, 8'hF0);
  endtask

  task automatic t_read_mask();
    logic [7:0] r;
    pad_in = 8'h5A;
    repeat (3) @(negedge clk);
    bus_read(win(8'hFF), r);
    check("R6 full mask reads pad not latch", r, 8'h5A);
    bus_read(win(8'h0F), r);
    check("R6 low nibble mask", r, 8'h0A);
    bus_read(win(8'h81), r);
    check("R6 pins 7,0 mask", r, 8'h00);
    bus_read(win(8'hF0), r);
    check("R6 high nibble mask", r, 8'h50);
  endtask

  task automatic t_sync();
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = win(8'hFF);
    pad_in = 8'hC3;
    @(negedge clk);
    check("R7 old value after edge 1", bus_rdata, 8'h5A);
    @(negedge clk);
    check("R7 old value after edge 2", bus_rdata, 8'h5A);
    @(negedge clk);
    check("R7 new value after edge 3", bus_rdata, 8'hC3);
    bus_en = 1'b0;
  endtask

  task automatic t_unmapped();
    logic [7:0] r;
    bus_write(12'h404, 8'h00);
    bus_write(12'h800, 8'h00);
    bus_write(12'hC3C, 8'h00);
    check("R8 pad_oe unchanged", pad_oe, 8'hFF);
    check("R8 pad_out unchanged", pad_out, 8'hF0);
    bus_read(12'h404, r);
    check("R8 unmapped read zero", r, 8'h00);
  endtask

  task automatic t_hold();
    logic [7:0] r;
    bus_read(12'h400, r);
    check("R9 dir read", r, 8'hFF);
    bus_write(win(8'hFF), 8'h3C);
    repeat (3) @(negedge clk);
    check("R9 rdata held", bus_rdata, 8'hFF);
    check("R3 write during hold", pad_out, 8'h3C);
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    rst_n = 1'b1; bus_en = 1'b0; bus_we = 1'b0;
    bus_addr = '0; bus_wdata = '0; pad_in = '0;
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    t_dir();
    t_masked_write();
    t_input_ignore();
    t_retain();
    t_read_mask();
    t_sync();
    t_unmapped();
    t_hold();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule